// File: doc/BRIEF.md
# High-Speed Data Lane Burst Framer

This block frames a single high-speed burst on one data lane of a serial link whose lanes switch between a low-power signalling mode and a high-speed differential mode. The core clock is taken as the unit interval (UI): every high-speed bit lasts one clock cycle, and every phase length is given in cycles. From the idle stop level the framer announces a burst with two low-power steps. It then drives a differential zero and sends a fixed sync byte. After that it streams payload bytes taken over a valid/ready byte interface. It closes the burst with a trail that holds the inverse of the final bit, then drives the stop level for an exit interval before it will take another request. Serialising across several lanes is not part of this block.

The controller is one state machine with eight states. STOP is idle at LP-11. The move STOP to LP_REQUEST is taken when a request and the clock-lane ready flag are both high. LP_REQUEST drives LP-01 and moves to PREPARE when its timer runs out. PREPARE drives LP-00 and moves to HS_ZERO on timeout. HS_ZERO drives the differential zero and moves to SYNC on timeout. SYNC moves to PAYLOAD after eight bits. PAYLOAD moves to TRAIL after the final bit of a byte flagged last, or at once when no byte is offered at a byte boundary (an underrun). TRAIL moves to EXIT on timeout, and EXIT moves to STOP on timeout. A phase timer is reloaded on every state change, and a byte shifter serialises both the sync word and the payload.

Top module: `hs_lane_burst_tx`

## Requirements
- R1: After reset the lane is in STOP: lp_p=1, lp_n=0 is never seen; lp_p=1, lp_n=1, hs_en=0, hs_bit=0, tx_ready=0. Whenever hs_en=0, hs_bit is 0.
- R2: The burst leaves LP-11 only after a clock edge at which burst_req and clk_lane_rdy are both 1 while in STOP. A request without clk_lane_rdy leaves the lane at LP-11. LP-01 appears in the cycle after that edge.
- R3: LP-01 (lp_p=0, lp_n=1, hs_en=0) is held for max(len_lpx,1) cycles.
- R4: LP-00 (lp_p=0, lp_n=0, hs_en=0) is held for max(len_prep,len_lpx,1) cycles, so it never lasts less than the low-power length.
- R5: Next, hs_en=1 with hs_bit=0 is held for max(len_zero,1) cycles. While hs_en=1, lp_p and lp_n are both 0.
- R6: The sync byte 8'hB8 follows in exactly 8 cycles, least significant bit first (bit order 0,0,0,1,1,1,0,1).
- R7: Payload bytes are sent least significant bit first, one bit per cycle, with no gap between bytes. tx_ready is 1 only in PAYLOAD at a byte boundary. A byte is taken in a cycle where tx_ready and tx_valid are both 1, and its bit 0 appears on hs_bit in that same cycle.
- R8: A byte taken with tx_last=1 is followed by TRAIL directly after its bit 7.
- R9: If tx_valid is 0 at a payload byte boundary, that cycle is the first trail cycle. hs_bit then carries the inverse of the last bit sent (sync bit 7 if no payload byte was taken).
- R10: The trail drives hs_en=1 with hs_bit equal to the inverse of the last sent bit for max(len_trail,8) cycles in total.
- R11: After the trail, LP-11 is held for max(len_exit,len_lpx,1) cycles before STOP. A request present during this exit interval does not shorten it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one UI per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| burst_req | input | 1 | Request to start a burst, sampled in STOP |
| clk_lane_rdy | input | 1 | Clock lane is running high-speed |
| tx_data | input | 8 | Payload byte |
| tx_valid | input | 1 | tx_data holds a byte |
| tx_last | input | 1 | Byte on tx_data is the last of the burst |
| tx_ready | output | 1 | Framer takes a byte this cycle |
| len_lpx | input | 8 | Minimum low-power state length, cycles |
| len_prep | input | 8 | LP-00 prepare length, cycles |
| len_zero | input | 8 | High-speed zero length, cycles |
| len_trail | input | 8 | Trail length, cycles |
| len_exit | input | 8 | Exit LP-11 length, cycles |
| lp_p | output | 1 | Low-power level of the positive wire |
| lp_n | output | 1 | Low-power level of the negative wire |
| hs_en | output | 1 | High-speed driver enabled |
| hs_bit | output | 1 | High-speed serial bit |

## Verification
The main framing is run over a table of phase-length sets. These include zero lengths, which must be raised to one cycle, and prepare and exit values below the low-power length, which must be raised to it. A trail below eight cycles must be raised to eight. Payload sizes of one to four bytes, each with a distinct bit pattern, show whether bit order, byte back-to-back timing and the inverted trail bit are right. Two underrun cases, one after two bytes and one with no payload at all, test the early-trail path and which bit is inverted. Directed tests hold a request without the clock-lane ready flag, offer data while idle, and keep a request high during exit to show the exit interval is not cut short.

// File: rtl/hslane_pkg.sv
package hslane_pkg;

    // Controller states of the burst framer
    typedef enum logic [2:0] {
        ST_STOP    = 3'd0,
        ST_LPREQ   = 3'd1,
        ST_PREP    = 3'd2,
        ST_ZERO    = 3'd3,
        ST_SYNC    = 3'd4,
        ST_PAYLOAD = 3'd5,
        ST_TRAIL   = 3'd6,
        ST_EXIT    = 3'd7
    } lane_state_e;

endpackage

// File: rtl/hslane_phase_timer.sv
module hslane_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_val;
        end else if (remain != '0) begin
            remain <= remain - CNT_W'(1);
        end
    end

    assign expired = (remain == '0);

endmodule

// File: rtl/hslane_byte_shifter.sv
module hslane_byte_shifter #(
    parameter int                BYTE_W    = 8,
    parameter logic [BYTE_W-1:0] SYNC_WORD = 8'hB8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_load,
    input  logic              sync_shift,
    input  logic              pay_active,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_last,
    output logic              out_bit,
    output logic              at_boundary,
    output logic              at_final,
    output logic              byte_last
);

    localparam int               IDX_W    = $clog2(BYTE_W);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BYTE_W - 1);

    logic [BYTE_W-1:0] shreg;
    logic [IDX_W-1:0]  idx;
    logic              take;
    logic              advance;

    assign at_boundary = (idx == '0);
    assign at_final    = (idx == IDX_LAST);
    assign take        = pay_active && at_boundary && in_valid;
    assign advance     = sync_shift || (pay_active && !at_boundary);
    assign out_bit     = (pay_active && at_boundary) ? in_data[0] : shreg[0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg     <= '0;
            idx       <= '0;
            byte_last <= 1'b0;
        end else if (sync_load) begin
            shreg     <= SYNC_WORD;
            idx       <= '0;
            byte_last <= 1'b0;
        end else if (advance) begin
            shreg <= shreg >> 1;
            idx   <= at_final ? '0 : idx + IDX_W'(1);
        end else if (take) begin
            shreg     <= in_data >> 1;
            idx       <= IDX_W'(1);
            byte_last <= in_last;
        end
    end

    // A byte boundary is only left by taking a byte
    AST_BOUNDARY_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (pay_active && at_boundary && !sync_load) |=> (at_boundary || $past(in_valid))) else $error("boundary"); // R7

endmodule

// File: rtl/hs_lane_burst_tx.sv
module hs_lane_burst_tx #(
    parameter int                LEN_W     = 8,
    parameter int                BYTE_W    = 8,
    parameter logic [BYTE_W-1:0] SYNC_WORD = 8'hB8,
    parameter int                MIN_TRAIL = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              burst_req,
    input  logic              clk_lane_rdy,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              tx_valid,
    input  logic              tx_last,
    output logic              tx_ready,
    input  logic [LEN_W-1:0]  len_lpx,
    input  logic [LEN_W-1:0]  len_prep,
    input  logic [LEN_W-1:0]  len_zero,
    input  logic [LEN_W-1:0]  len_trail,
    input  logic [LEN_W-1:0]  len_exit,
    output logic              lp_p,
    output logic              lp_n,
    output logic              hs_en,
    output logic              hs_bit
);
    import hslane_pkg::*;

    localparam int               DW       = LEN_W + 1;
    localparam logic [LEN_W-1:0] ONE      = LEN_W'(1);
    localparam logic [LEN_W-1:0] TRAIL_LO = LEN_W'(MIN_TRAIL);

    lane_state_e state, state_nxt;

    logic             tmr_load;
    logic [LEN_W-1:0] tmr_val;
    logic             tmr_done;
    logic             sh_bit, sh_bound, sh_final, sh_last;
    logic             sync_load;
    logic             underrun;
    logic             last_bit;

    // Effective phase lengths after the minimum rules
    logic [LEN_W-1:0] eff_lpx, eff_prep, eff_zero, eff_trail, eff_exit;

    assign eff_lpx   = (len_lpx  == '0) ? ONE : len_lpx;
    assign eff_prep  = (len_prep  > eff_lpx) ? len_prep : eff_lpx;
    assign eff_zero  = (len_zero == '0) ? ONE : len_zero;
    assign eff_trail = (len_trail > TRAIL_LO) ? len_trail : TRAIL_LO;
    assign eff_exit  = (len_exit  > eff_lpx) ? len_exit : eff_lpx;

    assign underrun  = (state == ST_PAYLOAD) && sh_bound && !tx_valid;
    assign sync_load = (state == ST_ZERO) && (state_nxt == ST_SYNC);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_STOP;
        end else begin
            state <= state_nxt;
        end
    end

    // Transition logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_STOP:    if (burst_req && clk_lane_rdy) state_nxt = ST_LPREQ;
            ST_LPREQ:   if (tmr_done) state_nxt = ST_PREP;
            ST_PREP:    if (tmr_done) state_nxt = ST_ZERO;
            ST_ZERO:    if (tmr_done) state_nxt = ST_SYNC;
            ST_SYNC:    if (sh_final) state_nxt = ST_PAYLOAD;
            ST_PAYLOAD: if (underrun || (sh_final && sh_last)) state_nxt = ST_TRAIL;
            ST_TRAIL:   if (tmr_done) state_nxt = ST_EXIT;
            ST_EXIT:    if (tmr_done) state_nxt = ST_STOP;
        endcase
    end

    // Timer reload on every state change
    always_comb begin
        tmr_load = (state_nxt != state);
        tmr_val  = '0;
        unique case (state_nxt)
            ST_LPREQ: tmr_val = eff_lpx - ONE;
            ST_PREP:  tmr_val = eff_prep - ONE;
            ST_ZERO:  tmr_val = eff_zero - ONE;
            ST_TRAIL: tmr_val = underrun ? eff_trail - LEN_W'(2) : eff_trail - ONE;
            ST_EXIT:  tmr_val = eff_exit - ONE;
            default:  tmr_val = '0;
        endcase
    end

    // Last high-speed data bit put on the line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_bit <= 1'b0;
        end else if ((state == ST_SYNC) || ((state == ST_PAYLOAD) && !underrun)) begin
            last_bit <= sh_bit;
        end
    end

    // Line outputs
    always_comb begin
        lp_p     = 1'b0;
        lp_n     = 1'b0;
        hs_en    = 1'b0;
        hs_bit   = 1'b0;
        tx_ready = 1'b0;
        unique case (state)
            ST_STOP, ST_EXIT: begin
                lp_p = 1'b1;
                lp_n = 1'b1;
            end
            ST_LPREQ: lp_n = 1'b1;
            ST_PREP:  ;
            ST_ZERO:  hs_en = 1'b1;
            ST_SYNC: begin
                hs_en  = 1'b1;
                hs_bit = sh_bit;
            end
            ST_PAYLOAD: begin
                hs_en    = 1'b1;
                tx_ready = sh_bound;
                hs_bit   = underrun ? ~last_bit : sh_bit;
            end
            ST_TRAIL: begin
                hs_en  = 1'b1;
                hs_bit = ~last_bit;
            end
        endcase
    end

    hslane_phase_timer #(.CNT_W(LEN_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    hslane_byte_shifter #(.BYTE_W(BYTE_W), .SYNC_WORD(SYNC_WORD)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .sync_load   (sync_load),
        .sync_shift  (state == ST_SYNC),
        .pay_active  (state == ST_PAYLOAD),
        .in_valid    (tx_valid),
        .in_data     (tx_data),
        .in_last     (tx_last),
        .out_bit     (sh_bit),
        .at_boundary (sh_bound),
        .at_final    (sh_final),
        .byte_last   (sh_last)
    );

    // Dwell counter used only by the assertions below
    logic [DW-1:0] dwell, dwell_p1;
    assign dwell_p1 = dwell + DW'(1);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dwell <= '0;
        end else if (state_nxt != state) begin
            dwell <= '0;
        end else if (dwell != '1) begin
            dwell <= dwell_p1;
        end
    end

    AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP && !clk_lane_rdy) |=> (state == ST_STOP)) else $error("start"); // R2
    AST_PREP_MIN_LPX: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PREP && state_nxt != ST_PREP) |-> (dwell_p1 >= {1'b0, eff_lpx})) else $error("prep"); // R4
    AST_HS_LP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        hs_en |-> (!lp_p && !lp_n)) else $error("hs lp"); // R5
    AST_SYNC_EIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SYNC && state_nxt != ST_SYNC) |-> (dwell == DW'(BYTE_W - 1))) else $error("sync"); // R6
    AST_TRAIL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TRAIL && $past(state) == ST_TRAIL) |-> $stable(hs_bit)) else $error("trail"); // R10
    AST_EXIT_MIN_LPX: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXIT && state_nxt != ST_EXIT) |-> (dwell_p1 >= {1'b0, eff_lpx})) else $error("exit"); // R11

endmodule

// File: tb/hs_lane_burst_tx_tb.sv
module hs_lane_burst_tx_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       burst_req = 1'b0;
    logic       clk_lane_rdy = 1'b0;
    logic [7:0] tx_data = '0;
    logic       tx_valid = 1'b0;
    logic       tx_last = 1'b0;
    logic       tx_ready;
    logic [7:0] len_lpx = 8'd1, len_prep = 8'd1, len_zero = 8'd1, len_trail = 8'd8, len_exit = 8'd1;
    logic       lp_p, lp_n, hs_en, hs_bit;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    localparam logic [7:0] SYNC_B = 8'hB8;

    // {lpx, prep, zero, trail, exit, nbytes, underrun}
    localparam logic [55:0] VEC [6] = '{
        {8'd3, 8'd5, 8'd4, 8'd10, 8'd6,  8'd2, 8'd0},
        {8'd1, 8'd0, 8'd0, 8'd0,  8'd0,  8'd1, 8'd0},
        {8'd6, 8'd2, 8'd7, 8'd3,  8'd2,  8'd3, 8'd0},
        {8'd2, 8'd4, 8'd2, 8'd9,  8'd12, 8'd2, 8'd1},
        {8'd2, 8'd3, 8'd1, 8'd12, 8'd3,  8'd0, 8'd1},
        {8'd0, 8'd2, 8'd3, 8'd8,  8'd4,  8'd4, 8'd0}
    };

    hs_lane_burst_tx u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .burst_req    (burst_req),
        .clk_lane_rdy (clk_lane_rdy),
        .tx_data      (tx_data),
        .tx_valid     (tx_valid),
        .tx_last      (tx_last),
        .tx_ready     (tx_ready),
        .len_lpx      (len_lpx),
        .len_prep     (len_prep),
        .len_zero     (len_zero),
        .len_trail    (len_trail),
        .len_exit     (len_exit),
        .lp_p         (lp_p),
        .lp_n         (lp_n),
        .hs_en        (hs_en),
        .hs_bit       (hs_bit)
    );

    always #5 clk = ~clk;

    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic [7:0] byte_of(input int v, input int b);
        return 8'((v * 37) + (b * 91) + 5);
    endfunction

    // Check outputs shortly after a falling edge, then move to the next falling edge
    task automatic chk(input logic ep, input logic en, input logic eh, input logic eb,
                       input logic er, input string tag);
        #1;
        n_chk++;
        if ({lp_p, lp_n, hs_en, hs_bit, tx_ready} !== {ep, en, eh, eb, er}) begin
            n_fail++;
            $display("FAIL %s: got lp_p,lp_n,hs_en,hs_bit,ready=%b expected %b",
                     tag, {lp_p, lp_n, hs_en, hs_bit, tx_ready}, {ep, en, eh, eb, er});
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_len(input int v);
        len_lpx   = VEC[v][55:48];
        len_prep  = VEC[v][47:40];
        len_zero  = VEC[v][39:32];
        len_trail = VEC[v][31:24];
        len_exit  = VEC[v][23:16];
    endtask

    // Runs from the first LP-01 cycle through the exit interval
    task automatic body(input int v);
        int lpx_e, prep_e, zero_e, trail_e, exit_e, nb;
        bit ur;
        logic lastb;
        logic [7:0] d;
        lpx_e   = mx(VEC[v][55:48], 1);
        prep_e  = mx(VEC[v][47:40], lpx_e);
        zero_e  = mx(VEC[v][39:32], 1);
        trail_e = mx(VEC[v][31:24], 8);
        exit_e  = mx(VEC[v][23:16], lpx_e);
        nb      = VEC[v][15:8];
        ur      = VEC[v][0];
        for (int i = 0; i < lpx_e; i++)  chk(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R3 LP-01");
        for (int i = 0; i < prep_e; i++) chk(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R4 LP-00");
        for (int i = 0; i < zero_e; i++) chk(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R5 HS-0");
        lastb = 1'b0;
        for (int k = 0; k < 8; k++) begin
            chk(1'b0, 1'b0, 1'b1, SYNC_B[k], 1'b0, "R6 sync");
            lastb = SYNC_B[k];
        end
        for (int b = 0; b < nb; b++) begin
            d        = byte_of(v, b);
            tx_data  = d;
            tx_valid = 1'b1;
            tx_last  = (b == nb - 1) && !ur;
            for (int k = 0; k < 8; k++) begin
                chk(1'b0, 1'b0, 1'b1, d[k], (k == 0), (b == nb - 1) ? "R8 last byte" : "R7 payload");
                if (k == 0) tx_valid = 1'b0;
                lastb = d[k];
            end
        end
        tx_valid = 1'b0;
        tx_last  = 1'b0;
        if (ur) begin
            chk(1'b0, 1'b0, 1'b1, ~lastb, 1'b1, "R9 underrun");
            for (int i = 1; i < trail_e; i++) chk(1'b0, 1'b0, 1'b1, ~lastb, 1'b0, "R9 trail");
        end else begin
            for (int i = 0; i < trail_e; i++) chk(1'b0, 1'b0, 1'b1, ~lastb, 1'b0, "R10 trail");
        end
        burst_req = 1'b1;  // must not shorten exit
        for (int i = 0; i < exit_e; i++) chk(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R11 exit");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R1 reset");

        // Request held without clock-lane ready, data offered while idle
        set_len(0);
        burst_req = 1'b1;
        tx_valid  = 1'b1;
        for (int i = 0; i < 5; i++) chk(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R2 no clk ready");
        tx_valid = 1'b0;
        clk_lane_rdy = 1'b1;
        chk(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R2 start edge");
        burst_req = 1'b0;
        body(0);

        for (int v = 1; v < 6; v++) begin
            set_len(v);
            burst_req = 1'b1;
            chk(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R11 stop before restart");
            burst_req = 1'b0;
            body(v);
        end

        burst_req = 1'b0;
        for (int i = 0; i < 4; i++) chk(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R2 idle");

        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule